// File: doc/BRIEF.md
# Variable-Length Recirculating Field Register

This block holds a serial pattern of up to 64 bits and plays it out one bit per clock. The loop is closed at a programmable stage. Each bit that leaves the output is written back into the chain. The pattern therefore repeats with no separate storage, and its period is the programmed length.

A configuration step first shifts the pattern in serially. A sequencer then enables the field, and the field replays the pattern. The field counts completed passes through the loop. On the last bit of the final programmed pass it raises a single-cycle completion pulse. After that pulse the pass count starts over and the pattern keeps cycling.

The first bit loaded is the first bit played. Holding the enable low freezes the field where it is. A start pulse clears the pass count without disturbing the stored bits.

Top module: `vlen_field`

## Requirements
- R1: After reset, `pat_out` is 0 and `done` is 0, and all 64 stored bits are 0.
- R2: While `load_en` is 1, `load_bit` shifts in one bit per clock. After 64 load clocks, the first bit loaded is on `pat_out`. During loading, `pat_out` shows the bit loaded 64 clocks earlier, or 0 if no bit was loaded then. The programmed length has no effect on loading.
- R3: While `run_en` is 1 and neither `load_en` nor `start` is 1, the field advances one bit per clock. `pat_out` then repeats the first L loaded bits in load order with period L, where L is `len_cfg`. Stored bits beyond the first L are not disturbed.
- R4: A `len_cfg` of 0 selects a length of 64.
- R5: `done` is 1 for exactly the cycle in which the last bit of pass number N is on `pat_out`. N is `iter_limit`, and a value of 0 means 16384. The pass count then restarts from zero and output continues unbroken.
- R6: While `run_en`, `load_en` and `start` are all 0, `pat_out` holds its value. The bit position and pass count are kept, and `done` stays 0.
- R7: A `start` pulse with `load_en` at 0 clears the pass count. The field does not advance in that cycle, and `done` is 0 in that cycle.
- R8: `load_en` has priority over `start` and `run_en`. It also resets the bit position and the pass count, so the next run begins with the first loaded bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_en | input | 1 | Serial configuration shift enable |
| load_bit | input | 1 | Serial configuration data |
| len_cfg | input | 6 | Loop length, 0 means 64 |
| iter_limit | input | 14 | Passes per completion, 0 means 16384 |
| run_en | input | 1 | Advance enable from the sequencer |
| start | input | 1 | Clears the pass count |
| pat_out | output | 1 | Serial pattern output |
| done | output | 1 | Last bit of final pass |

## Verification
`pat_out` is the last stage of the register. A load or run clock therefore shows its new value one clock later, and the bench compares it to its model just after each falling edge. `done` is combinational from the inputs and the registered position and count. The bench checks it in the same cycle as the inputs, a few nanoseconds after it drives them and before the next rising edge. Only then does the queue-based model advance. Any slip of a single clock in rotation, pass counting or load alignment therefore appears as a mismatch in that same cycle.

// File: rtl/vlen_field.sv
module vlen_field #(
  parameter int MAX_LEN = 64,
  parameter int CNT_W   = 14
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load_en,
  input  logic                         load_bit,
  input  logic [$clog2(MAX_LEN)-1:0]   len_cfg,
  input  logic [CNT_W-1:0]             iter_limit,
  input  logic                         run_en,
  input  logic                         start,
  output logic                         pat_out,
  output logic                         done
);
  localparam int PW = $clog2(MAX_LEN);
  localparam int LW = $clog2(MAX_LEN + 1);
  localparam logic [PW-1:0]    POS_ONE = 1;
  localparam logic [LW-1:0]    LEN_ONE = 1;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  logic [MAX_LEN-1:0] sreg;
  logic [PW-1:0]      pos;
  logic [CNT_W-1:0]   pass_cnt;
  logic [LW-1:0]      eff_len;
  logic               adv, last_bit;

  assign eff_len  = (len_cfg == '0) ? LW'(MAX_LEN) : {1'b0, len_cfg};
  assign adv      = run_en & ~load_en & ~start;
  assign last_bit = ({1'b0, pos} == eff_len - LEN_ONE);
  assign done     = adv & last_bit & (pass_cnt == iter_limit - CNT_ONE);
  assign pat_out  = sreg[MAX_LEN-1];

  for (genvar i = 0; i < MAX_LEN; i++) begin : g_stage
    logic active, is_tap, d;
    assign active = (eff_len >= LW'(MAX_LEN - i));
    assign is_tap = (eff_len == LW'(MAX_LEN - i));
    if (i == 0) begin : g_first
      assign d = load_en ? load_bit : sreg[MAX_LEN-1];
    end else begin : g_rest
      assign d = (!load_en && is_tap) ? sreg[MAX_LEN-1] : sreg[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       sreg[i] <= 1'b0;
      else if (load_en || (adv && active)) sreg[i] <= d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      pass_cnt <= '0;
    end else if (load_en) begin
      pos      <= '0;
      pass_cnt <= '0;
    end else if (start) begin
      pass_cnt <= '0;
    end else if (adv) begin
      pos <= last_bit ? '0 : pos + POS_ONE;
      if (last_bit) pass_cnt <= done ? '0 : pass_cnt + CNT_ONE;
    end
  end
endmodule

module vlen_field_chk #(
  parameter int MAX_LEN = 64,
  parameter int CNT_W   = 14
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       load_en,
  input logic                       run_en,
  input logic                       start,
  input logic                       pat_out,
  input logic                       done,
  input logic                       prev_stage,
  input logic [$clog2(MAX_LEN)-1:0] pos,
  input logic [$clog2(MAX_LEN)-1:0] len_cfg,
  input logic [CNT_W-1:0]           pass_cnt
);
  logic [$clog2(MAX_LEN+1)-1:0] len_e;
  assign len_e = (len_cfg == '0) ? ($clog2(MAX_LEN+1))'(MAX_LEN) : {1'b0, len_cfg};

  p_load_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> pat_out == $past(prev_stage));
  p_done_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_en && !load_en && !start));
  p_done_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({1'b0, pos} == len_e - 1'b1));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !load_en && !start) |=> $stable(pat_out) && $stable(pos));
  p_start_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !load_en) |=> (pass_cnt == '0) && $stable(pat_out));
  p_load_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (pos == '0) && (pass_cnt == '0));
endmodule

bind vlen_field vlen_field_chk #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_en(load_en), .run_en(run_en), .start(start),
  .pat_out(pat_out), .done(done), .prev_stage(sreg[MAX_LEN-2]), .pos(pos),
  .len_cfg(len_cfg), .pass_cnt(pass_cnt)
);

// File: tb/tb_vlen_field.sv
`timescale 1ns/1ps
module tb_vlen_field;
  logic clk = 0, rst_n = 0;
  logic load_en = 0, load_bit = 0, run_en = 0, start = 0;
  logic [5:0]  len_cfg = 0;
  logic [13:0] iter_limit = 0;
  logic pat_out, done;
  int checks = 0, errors = 0;
  bit q[$];
  int pos = 0, cnt = 0;

  always #4 clk = ~clk;

  vlen_field dut (.clk(clk), .rst_n(rst_n), .load_en(load_en), .load_bit(load_bit),
    .len_cfg(len_cfg), .iter_limit(iter_limit), .run_en(run_en), .start(start),
    .pat_out(pat_out), .done(done));

  function automatic int eff_l();
    return (len_cfg == 0) ? 64 : int'(len_cfg);
  endfunction
  function automatic int eff_n();
    return (iter_limit == 0) ? 16384 : int'(iter_limit);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(bit ld, bit lb, bit rn, bit st, string tag);
    bit adv, ed;
    load_en = ld; load_bit = lb; run_en = rn; start = st;
    #2;
    adv = rn && !ld && !st;
    ed  = adv && (pos == eff_l() - 1) && (cnt == eff_n() - 1);
    chk(tag, "pat_out", int'(pat_out), int'(q[0]));
    chk(tag, "done", int'(done), int'(ed));
    @(posedge clk);
    if (ld) begin
      void'(q.pop_front()); q.push_back(lb); pos = 0; cnt = 0;
    end else if (st) begin
      cnt = 0;
    end else if (rn) begin
      bit x;
      x = q.pop_front();
      q.insert(eff_l() - 1, x);
      if (pos == eff_l() - 1) begin
        pos = 0;
        cnt = ed ? 0 : cnt + 1;
      end else pos++;
    end
    @(negedge clk);
  endtask

  task automatic load_word(logic [63:0] w, string tag);
    for (int i = 0; i < 64; i++) step(1, w[i], 0, 0, tag);
  endtask

  task automatic run_n(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b1, 1'b0, tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) q.push_back(1'b0);
    repeat (3) @(negedge clk);
    chk("R1", "pat_out", int'(pat_out), 0);
    chk("R1", "done", int'(done), 0);
    rst_n = 1;
    @(negedge clk);
    len_cfg = 6'd5; iter_limit = 14'd3;
    run_n(8, "R1");
    load_word(64'hA5C3_0F96_1E2D_B478, "R2");
    len_cfg = 6'd5; iter_limit = 14'd3;
    run_n(12, "R3");
    repeat (6) step(0, 0, 0, 0, "R6");
    run_n(20, "R5");
    step(0, 0, 1, 1, "R7");
    run_n(18, "R7");
    len_cfg = 6'd0; iter_limit = 14'd2;
    step(0, 0, 0, 1, "R7");
    run_n(140, "R4");
    len_cfg = 6'd1; iter_limit = 14'd4;
    step(0, 0, 0, 1, "R7");
    run_n(10, "R5");
    len_cfg = 6'd13; iter_limit = 14'd1;
    run_n(7, "R3");
    step(1, 1, 1, 1, "R8");
    load_word(64'h0123_4567_89AB_CDEF, "R8");
    len_cfg = 6'd37; iter_limit = 14'd0;
    run_n(90, "R5");
    repeat (4) step(0, 0, 0, 0, "R6");
    run_n(30, "R3");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule